// File: doc/BRIEF.md
# Serial register readback slave interface

This block is the device side of a framed serial port. The host pulls chip select low to open a frame and raises it to close the frame. While the frame is open, the block takes a 16-bit control word from the serial data input, most significant bit first, on falling edges of the serial clock. At the same time it shifts data out on two output lines.

In a normal frame the two lines carry a conversion stand-in: a free-running frame counter on line A and its bitwise inverse on line B. Such a frame may carry a readback request. It may instead carry a write command that loads one of three internal registers: a 12-bit configuration register and two 9-bit reference registers.

A readback request is honoured one frame later. In that frame, line A carries a tagged 16-bit image of the chosen register, followed by zeros, and line B stays at zero. Because the output frame also shifts in a new control word, readbacks and writes can be issued back to back.

The serial clock, chip select and data input are sampled by the system clock. Edges are found by comparing registered samples, so the serial clock must be slow against the system clock.

Top module: `rdbk_serial_slave`

## Requirements
- R1: After reset, the configuration register reads back as 000h and both reference registers read back as 1FFh. Both output lines are 0 whenever no frame is open.
- R2: A frame that does not follow an accepted readback request is a conversion frame. In it, line A shifts out the frame counter and line B shifts out the counter's inverse, MSB first, for 16 bits. The counter is 0 in the first such frame after reset and grows by one with each conversion frame.
- R3: A control word 0011 in bits [15:12] with bits [11:0] zero requests the configuration register. The next frame's line A carries {0011, cfg[11:0]}. Readback frames leave the frame counter unchanged.
- R4: Control words 0001 and 0010 (bits [11:0] zero) request reference register A and B respectively. The next frame's line A carries {code, ref[8:0], 000}.
- R5: In a readback frame, line A holds the 16-bit word on its first 16 bit slots and 0 on every later falling edge of that frame. Line B is 0 for the whole frame.
- R6: A readback request that closes after fewer than 48 serial clock falling edges is dropped, and the next frame is a conversion frame.
- R7: A readback code with any nonzero bit in [11:0] is not a request. Codes 0000 and the codes not listed in R3, R4 or R8 change nothing. After any of these words the next frame is a conversion frame.
- R8: Writes load registers when the frame closes, provided the frame had at least 16 falling edges, so the new value holds from the next frame on. Code 1000 loads the configuration register from bits [11:0]. Code 1001 loads reference A from bits [11:3], and code 1010 loads reference B from bits [11:3]. A shorter frame writes nothing.
- R9: The frame that outputs a readback word takes in its own control word, which may be another request or a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select; each low period is one frame |
| sclk | input | 1 | Serial clock, idle high; data moves on its falling edges |
| sdi | input | 1 | Serial control word input, MSB first |
| sdo_a | output | 1 | Serial output line A (conversion data or readback word) |
| sdo_b | output | 1 | Serial output line B (inverted conversion data, or zero) |

## Verification
The bench builds the block with its default parameters: 16-bit word, 9-bit reference registers and a 48-edge minimum frame. At these values every one of the sixteen opcodes can be swept as a request followed by a plain frame. Every frame's output is checked against an arithmetic model of the registers and the counter. Frame lengths of 15, 16, 47 and 48 edges cover both length limits. A run of reference B writes, each read back, checks the bit alignment with padding.

// File: rtl/rdbk_pkg.sv
package rdbk_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] CODE_NOP     = 4'b0000;
    localparam logic [OP_W-1:0] CODE_RD_REFA = 4'b0001;
    localparam logic [OP_W-1:0] CODE_RD_REFB = 4'b0010;
    localparam logic [OP_W-1:0] CODE_RD_CFG  = 4'b0011;
    localparam logic [OP_W-1:0] CODE_WR_CFG  = 4'b1000;
    localparam logic [OP_W-1:0] CODE_WR_REFA = 4'b1001;
    localparam logic [OP_W-1:0] CODE_WR_REFB = 4'b1010;

    function automatic logic is_rd_code(input logic [OP_W-1:0] code);
        return (code == CODE_RD_CFG) || (code == CODE_RD_REFA) || (code == CODE_RD_REFB);
    endfunction

    function automatic logic is_wr_code(input logic [OP_W-1:0] code);
        return (code == CODE_WR_CFG) || (code == CODE_WR_REFA) || (code == CODE_WR_REFB);
    endfunction

endpackage

// File: rtl/rdbk_pin_sync.sv
module rdbk_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic sdi_s
);

    typedef struct packed {
        logic cs_q;
        logic cs_p;
        logic sk_q;
        logic sk_p;
        logic sdi_q;
    } pin_st_t;

    pin_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cs_q  = cs_n;
        st_d.cs_p  = st_q.cs_q;
        st_d.sk_q  = sclk;
        st_d.sk_p  = st_q.sk_q;
        st_d.sdi_q = sdi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cs_q: 1'b1, cs_p: 1'b1, sk_q: 1'b1, sk_p: 1'b1, sdi_q: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_fall = st_q.sk_p & ~st_q.sk_q & ~st_q.cs_q;
    assign cs_fall   = st_q.cs_p & ~st_q.cs_q;
    assign cs_rise   = ~st_q.cs_p & st_q.cs_q;
    assign sdi_s     = st_q.sdi_q;

endmodule

// File: rtl/rdbk_regfile.sv
module rdbk_regfile
    import rdbk_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int REF_W   = 9,
    parameter int CFG_RST = 0,
    parameter int REF_RST = 511,
    localparam int CFG_W  = DATA_W - OP_W,
    localparam int PAD_W  = DATA_W - OP_W - REF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_word,
    input  logic [OP_W-1:0]   rd_code,
    output logic [DATA_W-1:0] rd_word,
    output logic [CFG_W-1:0]  cfg_o
);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [REF_W-1:0] refa;
        logic [REF_W-1:0] refb;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic [OP_W-1:0]  wr_code;
    logic [REF_W-1:0] wr_ref;

    assign wr_code = wr_word[DATA_W-1 -: OP_W];
    assign wr_ref  = wr_word[CFG_W-1 -: REF_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_code)
                CODE_WR_CFG:  st_d.cfg  = wr_word[CFG_W-1:0];
                CODE_WR_REFA: st_d.refa = wr_ref;
                CODE_WR_REFB: st_d.refb = wr_ref;
                default:      st_d      = st_q;
            endcase
        end
    end

    always_comb begin
        case (rd_code)
            CODE_RD_CFG:  rd_word = {rd_code, st_q.cfg};
            CODE_RD_REFA: rd_word = {rd_code, st_q.refa, {PAD_W{1'b0}}};
            CODE_RD_REFB: rd_word = {rd_code, st_q.refb, {PAD_W{1'b0}}};
            default:      rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= CFG_W'(CFG_RST);
            st_q.refa <= REF_W'(REF_RST);
            st_q.refb <= REF_W'(REF_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;

endmodule

// File: rtl/rdbk_framer.sv
module rdbk_framer
    import rdbk_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MIN_EDGES = 48,
    localparam int CNT_W    = $clog2(MIN_EDGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_fall,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rb_word,
    output logic [OP_W-1:0]   rd_code,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_word,
    output logic              sdo_a,
    output logic              sdo_b,
    output logic              active_o,
    output logic              rb_frame_o,
    output logic [CNT_W-1:0]  edges_o,
    output logic [DATA_W-1:0] conv_o
);

    localparam logic [CNT_W-1:0] EDGE_MIN  = CNT_W'(MIN_EDGES);
    localparam logic [CNT_W-1:0] EDGE_WORD = CNT_W'(DATA_W);
    localparam int LOW_W = DATA_W - OP_W;

    typedef struct packed {
        logic              active;
        logic              rb_frame;
        logic [CNT_W-1:0]  edges;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] txa;
        logic [DATA_W-1:0] txb;
        logic              pend;
        logic [OP_W-1:0]   pend_code;
        logic [DATA_W-1:0] conv;
    } fr_st_t;

    fr_st_t st_d, st_q;

    logic [OP_W-1:0]  rx_code;
    logic [LOW_W-1:0] rx_low;
    logic             long_frame;
    logic             full_word;

    assign rx_code    = st_q.rx[DATA_W-1 -: OP_W];
    assign rx_low     = st_q.rx[LOW_W-1:0];
    assign long_frame = st_q.edges >= EDGE_MIN;
    assign full_word  = st_q.edges >= EDGE_WORD;

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        if (cs_fall) begin
            st_d.active = 1'b1;
            st_d.edges  = '0;
            st_d.rx     = '0;
            if (st_q.pend) begin
                st_d.txa      = rb_word;
                st_d.txb      = '0;
                st_d.rb_frame = 1'b1;
                st_d.pend     = 1'b0;
            end else begin
                st_d.txa      = st_q.conv;
                st_d.txb      = ~st_q.conv;
                st_d.conv     = st_q.conv + 1'b1;
                st_d.rb_frame = 1'b0;
            end
        end else if (cs_rise) begin
            st_d.active    = 1'b0;
            st_d.rb_frame  = 1'b0;
            st_d.txa       = '0;
            st_d.txb       = '0;
            st_d.pend      = long_frame && is_rd_code(rx_code) && (rx_low == '0);
            st_d.pend_code = rx_code;
            wr_en          = full_word && is_wr_code(rx_code);
        end else if (sclk_fall && st_q.active) begin
            if (st_q.edges < EDGE_WORD) begin
                st_d.rx = {st_q.rx[DATA_W-2:0], sdi_s};
            end
            st_d.txa = {st_q.txa[DATA_W-2:0], 1'b0};
            st_d.txb = {st_q.txb[DATA_W-2:0], 1'b0};
            if (st_q.edges != EDGE_MIN) begin
                st_d.edges = st_q.edges + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_code    = st_q.pend_code;
    assign wr_word    = st_q.rx;
    assign sdo_a      = st_q.txa[DATA_W-1];
    assign sdo_b      = st_q.txb[DATA_W-1];
    assign active_o   = st_q.active;
    assign rb_frame_o = st_q.rb_frame;
    assign edges_o    = st_q.edges;
    assign conv_o     = st_q.conv;

endmodule

// File: rtl/rdbk_serial_slave.sv
module rdbk_serial_slave
    import rdbk_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int REF_W     = 9,
    parameter int MIN_EDGES = 48,
    parameter int CFG_RST   = 0,
    parameter int REF_RST   = 511
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo_a,
    output logic sdo_b
);

    localparam int CNT_W = $clog2(MIN_EDGES + 1);
    localparam int CFG_W = DATA_W - OP_W;

    logic              sclk_fall;
    logic              cs_fall;
    logic              cs_rise;
    logic              sdi_s;
    logic [DATA_W-1:0] rb_word;
    logic [OP_W-1:0]   rd_code;
    logic              wr_en;
    logic [DATA_W-1:0] wr_word;
    logic              fr_active;
    logic              fr_rb_frame;
    logic [CNT_W-1:0]  fr_edges;
    logic [DATA_W-1:0] fr_conv;
    logic [CFG_W-1:0]  cfg_cur;

    rdbk_pin_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sdi_s     (sdi_s)
    );

    rdbk_framer #(
        .DATA_W    (DATA_W),
        .MIN_EDGES (MIN_EDGES)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_fall  (sclk_fall),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .sdi_s      (sdi_s),
        .rb_word    (rb_word),
        .rd_code    (rd_code),
        .wr_en      (wr_en),
        .wr_word    (wr_word),
        .sdo_a      (sdo_a),
        .sdo_b      (sdo_b),
        .active_o   (fr_active),
        .rb_frame_o (fr_rb_frame),
        .edges_o    (fr_edges),
        .conv_o     (fr_conv)
    );

    rdbk_regfile #(
        .DATA_W  (DATA_W),
        .REF_W   (REF_W),
        .CFG_RST (CFG_RST),
        .REF_RST (REF_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .rd_code (rd_code),
        .rd_word (rb_word),
        .cfg_o   (cfg_cur)
    );

endmodule

// File: rtl/rdbk_serial_slave_chk.sv
module rdbk_serial_slave_chk #(
    parameter int DATA_W    = 16,
    parameter int MIN_EDGES = 48,
    parameter int CNT_W     = 6,
    parameter int CFG_W     = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sdo_a,
    input logic              sdo_b,
    input logic              active,
    input logic              rb_frame,
    input logic [CNT_W-1:0]  edges,
    input logic [DATA_W-1:0] conv,
    input logic              wr_en,
    input logic [CFG_W-1:0]  cfg
);

    // R1: lines are quiet outside a frame
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!sdo_a && !sdo_b));

    // R2: each conversion frame advances the counter by one
    p_conv_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active) && !rb_frame) |-> (conv == ($past(conv) + DATA_W'(1))));

    // R3: readback frames leave the counter alone
    p_conv_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active) && rb_frame) |-> $stable(conv));

    // R5: line B stays low during a readback frame
    p_rb_lineb_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rb_frame) |-> !sdo_b);

    // R6: edge count saturates at the minimum frame length
    p_edges_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edges <= CNT_W'(MIN_EDGES));

    // R8: configuration only changes on a write strobe
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg));

endmodule

bind rdbk_serial_slave rdbk_serial_slave_chk #(
    .DATA_W    (DATA_W),
    .MIN_EDGES (MIN_EDGES),
    .CNT_W     (CNT_W),
    .CFG_W     (CFG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sdo_a    (sdo_a),
    .sdo_b    (sdo_b),
    .active   (fr_active),
    .rb_frame (fr_rb_frame),
    .edges    (fr_edges),
    .conv     (fr_conv),
    .wr_en    (wr_en),
    .cfg      (cfg_cur)
);

// File: tb/rdbk_serial_slave_bench.sv
`timescale 1ns/1ps
module rdbk_serial_slave_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic sdi = 1'b0;
    logic sdo_a;
    logic sdo_b;

    int checks = 0;
    int fails  = 0;

    logic [11:0] m_cfg  = 12'h000;
    logic [8:0]  m_refa = 9'h1FF;
    logic [8:0]  m_refb = 9'h1FF;
    logic [15:0] m_conv = 16'h0000;
    logic        m_pend = 1'b0;
    logic [3:0]  m_code = 4'h0;

    rdbk_serial_slave u_rdbk_serial_slave (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .sdi   (sdi),
        .sdo_a (sdo_a),
        .sdo_b (sdo_b)
    );

    always #4 clk = ~clk;

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_rb(input logic [3:0] code);
        case (code)
            4'b0011: return {code, m_cfg};
            4'b0001: return {code, m_refa, 3'b000};
            4'b0010: return {code, m_refb, 3'b000};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic run_frame(input logic [15:0] word, input int nedges, input string tag);
        logic [15:0] ew_a;
        logic [15:0] ew_b;
        logic [79:0] got_a;
        logic [79:0] got_b;
        logic [79:0] exp_a;
        logic [79:0] exp_b;
        logic [3:0]  code;
        if (m_pend) begin
            ew_a   = model_rb(m_code);
            ew_b   = 16'h0000;
            m_pend = 1'b0;
        end else begin
            ew_a   = m_conv;
            ew_b   = ~m_conv;
            m_conv = m_conv + 16'd1;
        end
        got_a = '0; got_b = '0; exp_a = '0; exp_b = '0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i <= nedges; i++) begin
            got_a[79-i] = sdo_a;
            got_b[79-i] = sdo_b;
            exp_a[79-i] = (i < 16) ? ew_a[15-i] : 1'b0;
            exp_b[79-i] = (i < 16) ? ew_b[15-i] : 1'b0;
            if (i < nedges) begin
                sdi = (i < 16) ? word[15-i] : 1'b0;
                repeat (4) @(negedge clk);
                sclk = 1'b0;
                repeat (4) @(negedge clk);
                sclk = 1'b1;
                repeat (4) @(negedge clk);
            end
        end
        cs_n = 1'b1;
        sdi  = 1'b0;
        repeat (8) @(negedge clk);
        check(got_a == exp_a, {tag, " line A"}, got_a, exp_a);
        check(got_b == exp_b, {tag, " line B"}, got_b, exp_b);
        code = word[15:12];
        if (nedges >= 48 && (code == 4'b0011 || code == 4'b0001 || code == 4'b0010)
            && word[11:0] == 12'h000) begin
            m_pend = 1'b1;
            m_code = code;
        end
        if (nedges >= 16) begin
            case (code)
                4'b1000: m_cfg  = word[11:0];
                4'b1001: m_refa = word[11:3];
                4'b1010: m_refb = word[11:3];
                default: ;
            endcase
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: idle outputs after reset
        check((sdo_a == 1'b0) && (sdo_b == 1'b0), "R1 idle", {78'd0, sdo_a, sdo_b}, 80'd0);

        // R2: conversion frames, counter pattern
        run_frame(16'h0000, 48, "R2");
        run_frame(16'h0000, 20, "R2");
        // R1: reset values via readback
        run_frame(16'h3000, 48, "R2");
        run_frame(16'h1000, 48, "R1");
        run_frame(16'h2000, 48, "R1");
        run_frame(16'h0000, 48, "R1");

        // R8: config write then readback; R5: long output frame
        run_frame(16'h8ABC, 16, "R2");
        run_frame(16'h3000, 48, "R8");
        run_frame(16'h0000, 60, "R5");
        // R8: short write ignored
        run_frame(16'h8123, 15, "R8");
        run_frame(16'h3000, 48, "R8");
        run_frame(16'h0000, 48, "R8");
        // R6: short request dropped
        run_frame(16'h1000, 47, "R6");
        run_frame(16'h0000, 48, "R6");
        // R7: nonzero low bits, no request
        run_frame(16'h3001, 48, "R7");
        run_frame(16'h0000, 48, "R7");
        // R9: back-to-back readbacks and write inside an output frame
        run_frame(16'h9AAF, 16, "R7");
        run_frame(16'h3000, 48, "R9");
        run_frame(16'h1000, 48, "R9");
        run_frame(16'h8F0F, 48, "R9");
        run_frame(16'h3000, 48, "R9");
        run_frame(16'h0000, 48, "R9");

        // R3: sweep every opcode as a request, then a plain frame
        for (int c = 0; c < 16; c++) begin
            run_frame({c[3:0], 12'h000}, 48, "R3");
            run_frame(16'h0000, 48, "R3");
        end

        // R4: reference B alignment over several values
        for (int v = 0; v < 8; v++) begin
            logic [8:0] val;
            val = 9'(v * 73 + 5);
            run_frame({4'hA, val, 3'b101}, 16, "R4");
            run_frame(16'h2000, 48, "R4");
            run_frame(16'h0000, 48, "R4");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule